// File: doc/BRIEF.md
# Serial Port Status Flags

This block keeps the two data-path status flags of an asynchronous serial port and exposes them to a CPU through a small register bus. The first flag is `tx_empty`. It says the transmit holding register can take another byte. The second flag is `rx_full`. It says a received byte is waiting in the read buffer. The serial core sets each flag through event inputs. Software can only clear a flag, and only through a deliberate read-then-write-zero handshake. DMA accesses to the holding or read buffer clear the matching flag as a side effect.

Each flag has a private arming latch. A bus read that returns 1 for that flag arms it. A later bus write with 0 in that flag's bit then clears the flag. Any bus write disarms both flags. A flag that drops to 0 for any reason disarms itself. Each flag also drives an interrupt request: the flag AND a per-flag enable, taken through one register stage.

Top module: `ser_stat_reg`

## Requirements
- R1: After reset, `tx_empty` (bit 7 of `bus_rdata_o`) is 1, `rx_full` (bit 6) is 0, bits 5..0 are 0, and both interrupt outputs are 0.
- R2: `bus_rdata_o` always shows `tx_empty` at bit 7 and `rx_full` at bit 6, with all other bits at 0.
- R3: A bus write never sets a flag. Writing 1 in a flag's bit leaves it unchanged. Writing 0 leaves it unchanged unless the flag is armed.
- R4: A flag is armed by a bus read (`bus_sel_i`=1, `bus_we_i`=0) taken while it is 1. A bus write with 0 in its bit clears it on the next edge while armed. Any bus write in between disarms both flags.
- R5: While `tx_en_i` is 0, `tx_empty` is set and stays set.
- R6: A `tx_load_i` pulse (holding register moved into the shifter) sets `tx_empty`.
- R7: A `dma_tx_wr_i` pulse clears `tx_empty`.
- R8: A `rx_done_i` pulse (error-free frame moved into the read buffer) sets `rx_full`. A `dma_rx_rd_i` pulse clears it.
- R9: A set event wins over any clear (software or DMA) in the same cycle.
- R10: When a flag drops to 0, its arming is lost. After it is set again, a write of 0 does not clear it until it has been read as 1 again.
- R11: `tx_irq_o` and `rx_irq_o` equal flag AND enable, delayed by exactly one clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_sel_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Flag read data |
| tx_en_i | input | 1 | Transmitter enable |
| tx_load_i | input | 1 | Holding register moved to shifter |
| rx_done_i | input | 1 | Good frame moved to read buffer |
| dma_tx_wr_i | input | 1 | DMA wrote the holding register |
| dma_rx_rd_i | input | 1 | DMA read the read buffer |
| tx_irq_en_i | input | 1 | Transmit interrupt enable |
| rx_irq_en_i | input | 1 | Receive interrupt enable |
| tx_irq_o | output | 1 | Transmit interrupt request |
| rx_irq_o | output | 1 | Receive interrupt request |

## Verification
The hardest state to reach from the ports is a flag that is 1 but disarmed, where the disarming came from something other than plain reset. One path is an intervening write. The other is a hardware clear followed by a hardware re-set.

The bench sweeps every combination of four conditions, for both flags:
- preceding read present or absent;
- intervening all-ones write present or absent;
- written bit value;
- concurrent set event present or absent.

It predicts the result arithmetically for each combination. Dedicated sequences then cover two further cases. In the first, a DMA clear and re-set is placed between the arming read and the write of 0. In the second, a DMA clear is issued while the transmitter is disabled.

// File: rtl/ser_stat_pkg.sv
package ser_stat_pkg;
  localparam int unsigned REG_W     = 8;
  localparam int unsigned NUM_FLAGS = 2;
  localparam int unsigned IDX_TX    = 0;
  localparam int unsigned IDX_RX    = 1;
  localparam int unsigned TX_POS    = 7;
  localparam int unsigned RX_POS    = 6;
  localparam int unsigned FLAG_POS [NUM_FLAGS] = '{TX_POS, RX_POS};
  localparam logic [NUM_FLAGS-1:0] FLAG_RST = 2'b01;  // tx=1, rx=0
endpackage

// File: rtl/ser_stat_flag.sv
module ser_stat_flag #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_i,
  input  logic wr_i,
  input  logic wbit_i,
  input  logic set_i,
  input  logic hw_clr_i,
  output logic flag_o
);
  logic flag_q, flag_d, armed_q, armed_d, sw_clr;

  assign sw_clr = wr_i & ~wbit_i & armed_q;

  always_comb begin
    flag_d = flag_q;
    if (set_i)                  flag_d = 1'b1;  // set wins
    else if (sw_clr | hw_clr_i) flag_d = 1'b0;
  end

  // armed by a read of 1, dropped by any write or when flag goes low
  assign armed_d = ~wr_i & flag_d & (armed_q | (rd_i & flag_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q  <= RST_VAL;
      armed_q <= 1'b0;
    end else begin
      flag_q  <= flag_d;
      armed_q <= armed_d;
    end
  end

  assign flag_o = flag_q;

  // R3
  no_sw_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_q && !set_i) |=> !flag_q);
  // R4
  unarmed_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !armed_q && !hw_clr_i) |=> flag_q);
  // R4
  armed_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !wbit_i && armed_q && !set_i) |=> !flag_q);
  // R9
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_q);
  // R10
  disarm_on_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_q && !rd_i) |=> !armed_q);
endmodule

// File: rtl/ser_stat_irq.sv
module ser_stat_irq #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] flag_i,
  input  logic [N-1:0] en_i,
  output logic [N-1:0] irq_o
);
  logic [N-1:0] irq_q;
  logic         seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      irq_q  <= flag_i & en_i;
      seen_q <= 1'b1;
    end
  end

  assign irq_o = irq_q;

  // R11
  irq_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q |-> (irq_q == $past(flag_i & en_i)));
endmodule

// File: rtl/ser_stat_reg.sv
module ser_stat_reg
  import ser_stat_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_sel_i,
  input  logic             bus_we_i,
  input  logic [REG_W-1:0] bus_wdata_i,
  output logic [REG_W-1:0] bus_rdata_o,
  input  logic             tx_en_i,
  input  logic             tx_load_i,
  input  logic             rx_done_i,
  input  logic             dma_tx_wr_i,
  input  logic             dma_rx_rd_i,
  input  logic             tx_irq_en_i,
  input  logic             rx_irq_en_i,
  output logic             tx_irq_o,
  output logic             rx_irq_o
);
  logic                 rd, wr;
  logic [NUM_FLAGS-1:0] set_vec, clr_vec, flag_vec, en_vec, irq_vec;
  logic [REG_W-1:0]     used_mask;
  logic                 unused_wdata;

  assign rd = bus_sel_i & ~bus_we_i;
  assign wr = bus_sel_i &  bus_we_i;

  assign set_vec[IDX_TX] = ~tx_en_i | tx_load_i;
  assign set_vec[IDX_RX] = rx_done_i;
  assign clr_vec[IDX_TX] = dma_tx_wr_i;
  assign clr_vec[IDX_RX] = dma_rx_rd_i;
  assign en_vec[IDX_TX]  = tx_irq_en_i;
  assign en_vec[IDX_RX]  = rx_irq_en_i;

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    ser_stat_flag #(.RST_VAL(FLAG_RST[g])) i_flag (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .rd_i    (rd),
      .wr_i    (wr),
      .wbit_i  (bus_wdata_i[FLAG_POS[g]]),
      .set_i   (set_vec[g]),
      .hw_clr_i(clr_vec[g]),
      .flag_o  (flag_vec[g])
    );
  end

  always_comb begin
    bus_rdata_o = '0;
    used_mask   = '0;
    for (int i = 0; i < NUM_FLAGS; i++) begin
      bus_rdata_o[FLAG_POS[i]] = flag_vec[i];
      used_mask[FLAG_POS[i]]   = 1'b1;
    end
  end

  assign unused_wdata = ^(bus_wdata_i & ~used_mask);

  ser_stat_irq #(.N(NUM_FLAGS)) i_irq (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .flag_i(flag_vec),
    .en_i  (en_vec),
    .irq_o (irq_vec)
  );

  assign tx_irq_o = irq_vec[IDX_TX];
  assign rx_irq_o = irq_vec[IDX_RX];

  // R5
  tx_dis_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en_i |=> bus_rdata_o[TX_POS]);
  // R2
  rdata_spare_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rdata_o & ~used_mask) == '0);
endmodule

// File: tb/test_ser_stat_reg.sv
`timescale 1ns/1ps
module test_ser_stat_reg;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel = 0, we = 0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       tx_en = 1, tx_load = 0, rx_done = 0, dma_tx = 0, dma_rx = 0;
  logic       tx_ie = 0, rx_ie = 0;
  logic       tx_irq, rx_irq;
  int         checks = 0, errors = 0;
  bit         done = 0;

  always #10 clk = ~clk;

  ser_stat_reg i_ser_stat_reg (
    .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .bus_we_i(we),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .tx_en_i(tx_en),
    .tx_load_i(tx_load), .rx_done_i(rx_done), .dma_tx_wr_i(dma_tx),
    .dma_rx_rd_i(dma_rx), .tx_irq_en_i(tx_ie), .rx_irq_en_i(rx_ie),
    .tx_irq_o(tx_irq), .rx_irq_o(rx_irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one clock; inputs are driven and sampled 2 ns after the edge
  task automatic cyc();
    @(posedge clk); #2;
    sel = 0; we = 0; wdata = '0;
    tx_load = 0; rx_done = 0; dma_tx = 0; dma_rx = 0;
  endtask

  task automatic set_ev(input int f);
    if (f == 0) tx_load = 1; else rx_done = 1;
  endtask

  task automatic clr_ev(input int f);
    if (f == 0) dma_tx = 1; else dma_rx = 1;
  endtask

  task automatic bus_rd();
    sel = 1; we = 0; cyc();
  endtask

  task automatic bus_wr(input logic [7:0] d);
    sel = 1; we = 1; wdata = d; cyc();
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #35 rst_n = 1'b1;
    #7;
    // R1
    chk("R1 rdata", rdata, 8'h80);
    chk("R1 irq", {6'b0, tx_irq, rx_irq}, 8'h00);

    // R3 R4 R9 sweep: rd, intervening write, written bit, concurrent set
    for (int f = 0; f < 2; f++) begin
      for (int c = 0; c < 16; c++) begin
        logic rd_b, iw, wb, st, exp;
        int pos;
        rd_b = c[0]; iw = c[1]; wb = c[2]; st = c[3];
        pos  = (f == 0) ? 7 : 6;
        set_ev(f); cyc();
        if (rd_b) bus_rd();
        if (iw) bus_wr(8'hFF);
        wdata = 8'hFF; wdata[pos] = wb;
        if (st) set_ev(f);
        sel = 1; we = 1; cyc();
        exp = st | wb | ~rd_b | iw;
        chk($sformatf("R3/R4/R9 flag%0d case%0d", f, c), {7'b0, rdata[pos]}, {7'b0, exp});
        // R2: unaffected other flag and spare bits
        chk("R2 spare bits", rdata & 8'h3F, 8'h00);
      end
    end

    // R7 then R6
    clr_ev(0); cyc();
    chk("R7 dma tx clear", rdata & 8'h80, 8'h00);
    bus_wr(8'hFF);
    chk("R3 write 1 no set", rdata & 8'h80, 8'h00);
    tx_load = 1; cyc();
    chk("R6 tx load sets", rdata & 8'h80, 8'h80);

    // R8
    clr_ev(1); cyc();
    chk("R8 dma rx clear", rdata & 8'h40, 8'h00);
    rx_done = 1; cyc();
    chk("R8 rx done sets", rdata & 8'h40, 8'h40);

    // R10: arm, DMA clear, re-set, write 0 must not clear
    for (int f = 0; f < 2; f++) begin
      logic [7:0] m;
      m = (f == 0) ? 8'h80 : 8'h40;
      set_ev(f); cyc();
      bus_rd();
      clr_ev(f); cyc();
      set_ev(f); cyc();
      bus_wr(8'h00);
      chk($sformatf("R10 rearm needed flag%0d", f), rdata & m, m);
      bus_rd(); bus_wr(8'h00);
      chk($sformatf("R4 clear after reread flag%0d", f), rdata & m, 8'h00);
    end

    // R5: tx disabled holds set against DMA and armed write 0
    tx_en = 0; cyc();
    chk("R5 tx disable sets", rdata & 8'h80, 8'h80);
    clr_ev(0); cyc();
    chk("R5 dma clear ignored", rdata & 8'h80, 8'h80);
    bus_rd(); bus_wr(8'h00);
    chk("R5 sw clear ignored", rdata & 8'h80, 8'h80);
    tx_en = 1; cyc();

    // R11: irq sweep over flag and enable values
    for (int c = 0; c < 16; c++) begin
      logic tf, rf;
      tf = c[0]; rf = c[1];
      if (tf) tx_load = 1; else dma_tx = 1;
      if (rf) rx_done = 1; else dma_rx = 1;
      cyc(); cyc();
      tx_ie = c[2]; rx_ie = c[3];
      #1;
      chk($sformatf("R11 latency case%0d", c), {6'b0, tx_irq, rx_irq}, 8'h00);
      cyc();
      chk($sformatf("R11 irq case%0d", c), {6'b0, tx_irq, rx_irq},
          {6'b0, tf & c[2], rf & c[3]});
      tx_ie = 0; rx_ie = 0; cyc();
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule